// File: doc/BRIEF.md
# Receive DMA Channel with Early-Warning Interrupt

This block is one peripheral-to-memory DMA channel. It takes bytes from a serial receiver, one byte per request/acknowledge handshake, and writes each byte into a memory buffer. Software programs the start address, the buffer length N and a watermark. A control write then arms the channel. Each accepted byte goes out on the byte-wide memory write port in the same cycle the receiver presents it. After that byte the write address steps up by one and the remaining count steps down by one.

The channel has two interrupt causes. The first fires when the remaining count falls to the watermark. With a watermark of 1 it fires after byte N-1, which gives software time to prepare a negative acknowledge for the final byte. The second fires when the last byte has been written. Each cause has its own pending bit. The interrupt output is the OR of the two bits, and software clears the bits by writing ones. Once the buffer is complete the channel stops accepting requests until it is armed again.

Registers are selected by a 2-bit index. Index 0 holds the base address. Index 1 holds the length in bits [15:0] and the watermark in bits [23:16]. Index 2 is control: a write with bit 0 set arms the channel, and a read returns the active flag in bit 0 and the remaining count in bits [31:16]. Index 3 is status: bit 0 is the watermark pending bit and bit 1 is the end-of-buffer pending bit.

Top module: `dma_wm_chan`

## Requirements
- R1: After reset the channel is idle. The interrupt output, the acknowledge, the memory write enable, the status register and the control read-back are all 0.
- R2: A write to index 2 with bit 0 set loads the write address from index 0 and the remaining count from index 1 bits [15:0]. The channel becomes active only if that count is nonzero. Arming an active channel restarts it.
- R3: While the channel is active and not being armed in that cycle, a request is acknowledged in the same cycle. In that same cycle the memory write enable is high, the memory address is the current address and the memory data is the request's byte.
- R4: Each acknowledged byte adds one to the write address and subtracts one from the remaining count. Both changes appear after the clock edge that ends the transfer.
- R5: When a transfer brings the remaining count to a nonzero watermark, status bit 0 is set and the interrupt output rises after that edge.
- R6: A watermark of 0 never sets status bit 0. Only the end-of-buffer cause can interrupt.
- R7: The transfer that brings the remaining count to 0 sets status bit 1, raises the interrupt and makes the channel inactive.
- R8: While the channel is inactive, requests get no acknowledge and no memory write, and the remaining count stays the same.
- R9: The interrupt output is high while either status bit is set. Each bit stays set until a write to index 3 has a 1 in that bit's position. A 0 in a bit's position leaves that bit unchanged.
- R10: If status bit 0 is still set when the buffer completes, it stays set and status bit 1 is set as well.
- R11: If a transfer sets a status bit in the same cycle that software clears that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| per_req_i | input | 1 | Receiver has a byte |
| per_data_i | input | 8 | Received byte |
| per_ack_o | output | 1 | Byte taken this cycle |
| mem_we_o | output | 1 | Memory byte write enable |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| irq_o | output | 1 | Interrupt, OR of the status bits |

## Verification
The main path is tried with four buffer shapes. A four-byte buffer with watermark 1 checks that the early interrupt fires after byte N-1 and not before. A three-byte buffer with watermark 0 checks that the early cause is disabled. A two-byte buffer with watermark 1, where software leaves the first flag uncleared, checks that the two status bits are kept apart. A zero-length arm checks that the channel never starts. Further tests check that extra requests after completion and before arming are ignored, that re-arming in the middle of a buffer moves the write pointer to the new base, and that a transfer wins over a same-cycle software clear.

// File: rtl/dma_wm_pkg.sv
package dma_wm_pkg;
  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  localparam int REG_W    = 32;
  localparam int WM_LSB   = 16;
  localparam int CNT_RLSB = 16;
  localparam int ST_WM    = 0;
  localparam int ST_EOB   = 1;
  localparam int ST_N     = 2;
endpackage

// File: rtl/dma_wm_regs.sv
module dma_wm_regs
  import dma_wm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int WM_W   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [1:0]           sel_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic [ADDR_W-1:0]    base_o,
  output logic [CNT_W-1:0]     len_o,
  output logic [WM_W-1:0]      wm_o,
  output logic                 arm_o,
  output logic [ST_N-1:0]      clr_o,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 active_i,
  input  logic [ST_N-1:0]      pend_i
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      len_o  <= '0;
      wm_o   <= '0;
    end else if (we_i) begin
      if (sel == SEL_BASE) base_o <= wdata_i[ADDR_W-1:0];
      if (sel == SEL_LEN) begin
        len_o <= wdata_i[CNT_W-1:0];
        wm_o  <= wdata_i[WM_LSB +: WM_W];
      end
    end
  end

  assign arm_o = we_i && (sel == SEL_CTRL) && wdata_i[0];
  assign clr_o = (we_i && (sel == SEL_STAT)) ? wdata_i[ST_N-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_BASE: rdata_o[ADDR_W-1:0] = base_o;
      SEL_LEN: begin
        rdata_o[CNT_W-1:0]        = len_o;
        rdata_o[WM_LSB +: WM_W]   = wm_o;
      end
      SEL_CTRL: begin
        rdata_o[0]                = active_i;
        rdata_o[CNT_RLSB +: CNT_W] = cnt_i;
      end
      SEL_STAT: rdata_o[ST_N-1:0] = pend_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_wm_xfer.sv
module dma_wm_xfer #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int WM_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [WM_W-1:0]   wm_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              active_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wm_hit_o,
  output logic              eob_hit_o
);
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cnt_nx;
  logic [CNT_W-1:0]  wm_ext;

  assign cnt_nx = cnt_o - 1'b1;
  assign wm_ext = CNT_W'(wm_i);

  // arm has priority: the request waits one cycle
  assign ack_o       = active_o && req_i && !arm_i;
  assign mem_we_o    = ack_o;
  assign mem_addr_o  = cur_addr;
  assign mem_wdata_o = data_i;

  assign wm_hit_o  = ack_o && (wm_i != '0) && (cnt_nx == wm_ext);
  assign eob_hit_o = ack_o && (cnt_nx == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_addr <= '0;
      cnt_o    <= '0;
      active_o <= 1'b0;
    end else if (arm_i) begin
      cur_addr <= base_i;
      cnt_o    <= len_i;
      active_o <= (len_i != '0);
    end else if (ack_o) begin
      cur_addr <= cur_addr + 1'b1;
      cnt_o    <= cnt_nx;
      active_o <= (cnt_nx != '0);
    end
  end
endmodule

// File: rtl/dma_wm_irq.sv
module dma_wm_irq #(
  parameter int N_SRC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o,
  output logic             irq_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_o[g] <= 1'b0;
      else if (set_i[g]) pend_o[g] <= 1'b1;  // set beats clear
      else if (clr_i[g]) pend_o[g] <= 1'b0;
    end
  end

  assign irq_o = |pend_o;
endmodule

// File: rtl/dma_wm_chan.sv
module dma_wm_chan
  import dma_wm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int WM_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              per_req_i,
  input  logic [DATA_W-1:0] per_data_i,
  output logic              per_ack_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  len;
  logic [WM_W-1:0]   wm;
  logic              arm;
  logic [ST_N-1:0]   clr;
  logic [ST_N-1:0]   pend;
  logic [ST_N-1:0]   set;
  logic [CNT_W-1:0]  cnt;
  logic              active;
  logic              wm_hit;
  logic              eob_hit;

  dma_wm_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WM_W(WM_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .base_o  (base),
    .len_o   (len),
    .wm_o    (wm),
    .arm_o   (arm),
    .clr_o   (clr),
    .cnt_i   (cnt),
    .active_i(active),
    .pend_i  (pend)
  );

  dma_wm_xfer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WM_W(WM_W), .DATA_W(DATA_W)) u_xfer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm),
    .base_i     (base),
    .len_i      (len),
    .wm_i       (wm),
    .req_i      (per_req_i),
    .data_i     (per_data_i),
    .ack_o      (per_ack_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .active_o   (active),
    .cnt_o      (cnt),
    .wm_hit_o   (wm_hit),
    .eob_hit_o  (eob_hit)
  );

  always_comb begin
    set         = '0;
    set[ST_WM]  = wm_hit;
    set[ST_EOB] = eob_hit;
  end

  dma_wm_irq #(.N_SRC(ST_N)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set),
    .clr_i (clr),
    .pend_o(pend),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/dma_wm_chk.sv
module dma_wm_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              per_req_i,
  input logic [DATA_W-1:0] per_data_i,
  input logic              per_ack_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              irq_o,
  input logic              active_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [1:0]        pend_i
);
  logic arm_wr, stat_wr;
  assign arm_wr  = reg_we_i && (reg_addr_i == 2'd2) && reg_wdata_i[0];
  assign stat_wr = reg_we_i && (reg_addr_i == 2'd3);

  AST_ACK_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_ack_o |-> (per_req_i && active_i)); // R3
  AST_MEM_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_ack_o |-> (mem_we_o && mem_wdata_o == per_data_i)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_ack_o |=> (mem_addr_o == $past(mem_addr_o) + 1'b1)); // R4
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_ack_o |=> (cnt_i == $past(cnt_i) - 1'b1)); // R4
  AST_ACTIVE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (cnt_i != '0)); // R7
  AST_IDLE_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !arm_wr) |=> ($stable(cnt_i) && !active_i)); // R8
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !mem_we_o); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !stat_wr) |=> irq_o); // R9
  AST_WM_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i[0] && !(stat_wr && reg_wdata_i[0])) |=> pend_i[0]); // R10
endmodule

bind dma_wm_chan dma_wm_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .per_req_i  (per_req_i),
  .per_data_i (per_data_i),
  .per_ack_o  (per_ack_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .irq_o      (irq_o),
  .active_i   (active),
  .cnt_i      (cnt),
  .pend_i     (pend)
);

// File: tb/dma_wm_chan_tb.sv
module dma_wm_chan_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        per_req_i = 1'b0;
  logic [7:0]  per_data_i = '0;
  logic        per_ack_o;
  logic        mem_we_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  dma_wm_chan u_dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic setup(input logic [15:0] base, input logic [15:0] n, input logic [7:0] wm);
    wr(2'd0, {16'h0, base});
    wr(2'd1, {8'h0, wm, n});
    wr(2'd2, 32'h1);
  endtask

  // one byte; checks same-cycle handshake and memory write
  task automatic push(input logic [7:0] b, input logic exp_ack, input logic [15:0] exp_addr);
    @(negedge clk_i);
    per_req_i = 1'b1; per_data_i = b;
    #1;
    check("R3 ack", per_ack_o, exp_ack);
    check("R3 mem_we", mem_we_o, exp_ack);
    if (exp_ack) begin
      check("R3 mem_addr", mem_addr_o, exp_addr);
      check("R3 mem_wdata", mem_wdata_o, b);
    end
    @(negedge clk_i);
    per_req_i = 1'b0;
  endtask

  task automatic expect_state(input string tag, input logic [15:0] rem, input logic act,
                              input logic [1:0] st, input logic irq);
    logic [31:0] d;
    rd(2'd2, d);
    check({tag, " remaining"}, d[31:16], rem);
    check({tag, " active"}, d[0], act);
    rd(2'd3, d);
    check({tag, " status"}, d[1:0], st);
    check({tag, " irq"}, irq_o, irq);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    #1;
    check("R1 irq", irq_o, 0);
    check("R1 ack", per_ack_o, 0);
    check("R1 mem_we", mem_we_o, 0);
    rd(2'd3, d); check("R1 status", d, 0);
    rd(2'd2, d); check("R1 ctrl", d, 0);
  endtask

  task automatic t_watermark_one();
    setup(16'h0100, 16'd4, 8'd1);
    expect_state("R2 armed", 16'd4, 1, 2'b00, 0);
    push(8'hA1, 1, 16'h0100);
    expect_state("R4 after byte1", 16'd3, 1, 2'b00, 0);
    push(8'hA2, 1, 16'h0101);
    expect_state("R5 not early", 16'd2, 1, 2'b00, 0);
    push(8'hA3, 1, 16'h0102);
    expect_state("R5 watermark hit", 16'd1, 1, 2'b01, 1);
    repeat (3) @(negedge clk_i);
    expect_state("R9 held", 16'd1, 1, 2'b01, 1);
    wr(2'd3, 32'h1);
    expect_state("R9 cleared", 16'd1, 1, 2'b00, 0);
    push(8'hA4, 1, 16'h0103);
    expect_state("R7 end", 16'd0, 0, 2'b10, 1);
    push(8'hEE, 0, 16'h0);
    expect_state("R8 after end", 16'd0, 0, 2'b10, 1);
    wr(2'd3, 32'h3);
    expect_state("R9 clear eob", 16'd0, 0, 2'b00, 0);
  endtask

  task automatic t_no_watermark();
    setup(16'h0040, 16'd3, 8'd0);
    push(8'h11, 1, 16'h0040);
    push(8'h22, 1, 16'h0041);
    expect_state("R6 no early", 16'd1, 1, 2'b00, 0);
    push(8'h33, 1, 16'h0042);
    expect_state("R6 eob only", 16'd0, 0, 2'b10, 1);
    wr(2'd3, 32'h3);
  endtask

  task automatic t_overlap();
    setup(16'h0300, 16'd2, 8'd1);
    push(8'h5A, 1, 16'h0300);
    expect_state("R5 wm n2", 16'd1, 1, 2'b01, 1);
    push(8'h5B, 1, 16'h0301);
    expect_state("R10 both", 16'd0, 0, 2'b11, 1);
    wr(2'd3, 32'h2);
    expect_state("R9 partial clear", 16'd0, 0, 2'b01, 1);
    wr(2'd3, 32'h1);
    expect_state("R9 all clear", 16'd0, 0, 2'b00, 0);
  endtask

  task automatic t_zero_len();
    setup(16'h0500, 16'd0, 8'd1);
    expect_state("R2 zero len", 16'd0, 0, 2'b00, 0);
    push(8'h77, 0, 16'h0);
    expect_state("R8 idle", 16'd0, 0, 2'b00, 0);
  endtask

  task automatic t_rearm();
    setup(16'h0600, 16'd5, 8'd0);
    push(8'h01, 1, 16'h0600);
    push(8'h02, 1, 16'h0601);
    wr(2'd0, 32'h0200);
    wr(2'd2, 32'h1);
    expect_state("R2 rearm", 16'd5, 1, 2'b00, 0);
    push(8'h03, 1, 16'h0200);
    expect_state("R4 rearm step", 16'd4, 1, 2'b00, 0);
  endtask

  task automatic t_set_wins();
    setup(16'h0700, 16'd2, 8'd0);
    push(8'h10, 1, 16'h0700);
    @(negedge clk_i);
    per_req_i = 1'b1; per_data_i = 8'h20;
    reg_we_i = 1'b1; reg_addr_i = 2'd3; reg_wdata_i = 32'h3;
    #1 check("R11 ack", per_ack_o, 1);
    @(negedge clk_i);
    per_req_i = 1'b0; reg_we_i = 1'b0; reg_wdata_i = '0;
    expect_state("R11 set wins", 16'd0, 0, 2'b10, 1);
    wr(2'd3, 32'h3);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_watermark_one();
    t_no_watermark();
    t_overlap();
    t_zero_len();
    t_rearm();
    t_set_wins();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule